// File: doc/BRIEF.md
# CHS to Linear Byte Offset Converter

This block turns a disk address held in task-file style registers into the byte offset at which a sector transfer begins. A host raises `start` for one cycle with the sector-number, cylinder-low, cylinder-high and drive/head register values on the inputs, together with the geometry of the selected drive (heads per cylinder, sectors per track) and its sector size in bytes. Exactly three cycles later the block pulses `done` with the 48-bit offset. If the requested address cannot be translated, `addr_err` is asserted in that same cycle and the offset reads zero.

Two addressing modes exist. In cylinder/head/sector mode, the cylinder is formed from the two cylinder registers, the head from the drive/head register, and the 1-based sector number is folded in with the runtime geometry. In linear mode, the three address registers are concatenated into a 24-bit sector index and the geometry is not used.

A controller with four named states sequences one shared multiply-add unit: `ST_IDLE` (waiting; transition T_ACCEPT to `ST_FOLD` on `start`), `ST_FOLD` (cylinder times heads plus head; transition T_FOLD to `ST_TRACK`), `ST_TRACK` (times sectors per track plus sector minus one; transition T_TRACK to `ST_SCALE`) and `ST_SCALE` (times sector size, result registered; transition T_FINISH back to `ST_IDLE`).

Top module: `chs_offset_unit`

## Requirements
- R1: While `rst_n` is low and after its release with no start, `busy`, `done` and `addr_err` are 0 and `offset` is 0.
- R2: The head number is bits [3:0] of `drv_head`; bits [7:4] have no effect on the result.
- R3: The cylinder number is `cyl_hi` in bits [15:8] and `cyl_lo` in bits [7:0].
- R4: With `lba_mode` = 0 and a valid geometry, `offset` = bytes × ((cylinder × `geo_heads` + head) × `geo_spt` + `sec_num` − 1).
- R5: With `lba_mode` = 0 and `geo_heads` = 0 or `geo_spt` = 0, `addr_err` = 1 together with `done` and `offset` = 0.
- R6: With `lba_mode` = 0 and `sec_num` = 0, `addr_err` = 1 together with `done` and `offset` = 0.
- R7: A `sec_bytes` value of 0 selects a sector size of 512 bytes; any other value is used as given.
- R8: With `lba_mode` = 1, `offset` = bytes × ({`cyl_hi`, `cyl_lo`, `sec_num`} as a 24-bit index), `addr_err` = 0 and the geometry inputs have no effect.
- R9: When `start` is sampled high while `busy` = 0, `busy` is 1 for the next three cycles and `done` is a one-cycle pulse in the cycle after them, with `busy` = 0.
- R10: All inputs are captured when a start is accepted; a `start` while `busy` = 1 and input changes after acceptance have no effect.
- R11: `offset` and `addr_err` keep their value from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion (accepted only when idle) |
| lba_mode | input | 1 | 1 selects linear addressing, 0 cylinder/head/sector |
| sec_num | input | 8 | Sector-number register |
| cyl_lo | input | 8 | Cylinder register, low byte |
| cyl_hi | input | 8 | Cylinder register, high byte |
| drv_head | input | 8 | Drive/head register (head in bits [3:0]) |
| geo_heads | input | 5 | Heads per cylinder (0 to 16) |
| geo_spt | input | 8 | Sectors per track |
| sec_bytes | input | 16 | Sector size in bytes, 0 means 512 |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| addr_err | output | 1 | Address not translatable, valid from `done` |
| offset | output | 48 | Starting byte offset, valid from `done` |

## Verification
A controller stuck in or skipping a state shows up at once as `busy` of the wrong length or a `done` pulse one cycle early, late or missing, because the bench predicts both signals on every clock. An operand multiplexer feeding the shared multiplier the wrong term for a state gives a wrong `offset` at the very next `done`, and the patterns are chosen so that head, cylinder halves, sector base and byte size each move the result separately. Capture faults show up only when inputs change during a conversion, so the bench changes them on purpose while `busy` is high.

// File: rtl/chs_pkg.sv
package chs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FOLD  = 2'd1,
        ST_TRACK = 2'd2,
        ST_SCALE = 2'd3
    } chs_state_e;

endpackage

// File: rtl/chs_mac.sv
module chs_mac #(
    parameter int A_W = 48,
    parameter int B_W = 16,
    parameter int C_W = 16,
    parameter int R_W = 48
) (
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic [C_W-1:0] c_i,
    output logic [R_W-1:0] r_o
);
    localparam int P_W = A_W + B_W;

    logic [P_W-1:0] prod;

    assign prod = P_W'(a_i) * P_W'(b_i);
    assign r_o  = prod[R_W-1:0] + R_W'(c_i);

endmodule

// File: rtl/chs_err_check.sv
module chs_err_check #(
    parameter int HEADS_W = 5,
    parameter int SPT_W   = 8,
    parameter int SEC_W   = 8
) (
    input  logic               lba_i,
    input  logic [HEADS_W-1:0] heads_i,
    input  logic [SPT_W-1:0]   spt_i,
    input  logic [SEC_W-1:0]   sec_i,
    output logic               err_o
);
    logic geo_bad;
    logic sec_bad;

    assign geo_bad = (heads_i == '0) || (spt_i == '0);
    assign sec_bad = (sec_i == '0);
    assign err_o   = !lba_i && (geo_bad || sec_bad);

endmodule

// File: rtl/chs_ctrl.sv
module chs_ctrl
    import chs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output chs_state_e state_o,
    output logic       accept_o,
    output logic       busy_o,
    output logic       last_o
);
    chs_state_e state_q;
    chs_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FOLD;
            ST_FOLD:  state_d = ST_TRACK;
            ST_TRACK: state_d = ST_SCALE;
            ST_SCALE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_o = 1'b0;
        busy_o   = 1'b1;
        last_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_FOLD:  ;
            ST_TRACK: ;
            ST_SCALE: last_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/chs_offset_unit.sv
module chs_offset_unit
    import chs_pkg::*;
#(
    parameter int REG_W         = 8,
    parameter int HEAD_FIELD_W  = 4,
    parameter int HEADS_W       = 5,
    parameter int BYTES_W       = 16,
    parameter int OFF_W         = 48,
    parameter int DEFAULT_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               lba_mode,
    input  logic [REG_W-1:0]   sec_num,
    input  logic [REG_W-1:0]   cyl_lo,
    input  logic [REG_W-1:0]   cyl_hi,
    input  logic [REG_W-1:0]   drv_head,
    input  logic [HEADS_W-1:0] geo_heads,
    input  logic [REG_W-1:0]   geo_spt,
    input  logic [BYTES_W-1:0] sec_bytes,
    output logic               busy,
    output logic               done,
    output logic               addr_err,
    output logic [OFF_W-1:0]   offset
);
    localparam int CYL_W = 2 * REG_W;
    localparam int LBA_W = 3 * REG_W;
    localparam int MUL_W = (BYTES_W > REG_W) ? BYTES_W : REG_W;
    localparam int ADD_W = REG_W;

    chs_state_e state;
    logic       accept;
    logic       last;
    logic       err_now;

    logic [CYL_W-1:0]        r_cyl;
    logic [HEAD_FIELD_W-1:0] r_head;
    logic [REG_W-1:0]        r_sec;
    logic [HEADS_W-1:0]      r_heads;
    logic [REG_W-1:0]        r_spt;
    logic [BYTES_W-1:0]      r_bytes;
    logic                    r_lba;
    logic                    r_err;
    logic [OFF_W-1:0]        acc;

    logic [OFF_W-1:0] mac_a;
    logic [MUL_W-1:0] mac_b;
    logic [ADD_W-1:0] mac_c;
    logic [OFF_W-1:0] mac_r;

    logic unused_head_hi;
    assign unused_head_hi = ^drv_head[REG_W-1:HEAD_FIELD_W];

    chs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .state_o  (state),
        .accept_o (accept),
        .busy_o   (busy),
        .last_o   (last)
    );

    chs_err_check #(
        .HEADS_W (HEADS_W),
        .SPT_W   (REG_W),
        .SEC_W   (REG_W)
    ) u_err (
        .lba_i   (lba_mode),
        .heads_i (geo_heads),
        .spt_i   (geo_spt),
        .sec_i   (sec_num),
        .err_o   (err_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_cyl   <= '0;
            r_head  <= '0;
            r_sec   <= '0;
            r_heads <= '0;
            r_spt   <= '0;
            r_bytes <= '0;
            r_lba   <= 1'b0;
            r_err   <= 1'b0;
        end else if (accept) begin
            r_cyl   <= {cyl_hi, cyl_lo};
            r_head  <= drv_head[HEAD_FIELD_W-1:0];
            r_sec   <= sec_num;
            r_heads <= geo_heads;
            r_spt   <= geo_spt;
            r_bytes <= (sec_bytes == '0) ? BYTES_W'(DEFAULT_BYTES) : sec_bytes;
            r_lba   <= lba_mode;
            r_err   <= err_now;
        end
    end

    always_comb begin
        mac_a = '0;
        mac_b = '0;
        mac_c = '0;
        unique case (state)
            ST_IDLE: ;
            ST_FOLD: begin
                if (r_lba) begin
                    mac_a = OFF_W'({r_cyl, r_sec});
                    mac_b = MUL_W'(1);
                end else begin
                    mac_a = OFF_W'(r_cyl);
                    mac_b = MUL_W'(r_heads);
                    mac_c = ADD_W'(r_head);
                end
            end
            ST_TRACK: begin
                mac_a = acc;
                if (r_lba) begin
                    mac_b = MUL_W'(1);
                end else begin
                    mac_b = MUL_W'(r_spt);
                    mac_c = r_err ? '0 : ADD_W'(r_sec - 1'b1);
                end
            end
            ST_SCALE: begin
                mac_a = acc;
                mac_b = MUL_W'(r_bytes);
            end
        endcase
    end

    chs_mac #(
        .A_W (OFF_W),
        .B_W (MUL_W),
        .C_W (ADD_W),
        .R_W (OFF_W)
    ) u_mac (
        .a_i (mac_a),
        .b_i (mac_b),
        .c_i (mac_c),
        .r_o (mac_r)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (state == ST_FOLD || state == ST_TRACK) begin
            acc <= mac_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            addr_err <= 1'b0;
            offset   <= '0;
        end else begin
            done <= last;
            if (last) begin
                addr_err <= r_err;
                offset   <= r_err ? '0 : mac_r;
            end
        end
    end

    // LBA index width kept for reference in derived sizing
    logic unused_lba_w;
    assign unused_lba_w = (LBA_W > OFF_W);

endmodule

// File: rtl/chs_offset_chk.sv
module chs_offset_chk #(
    parameter int OFF_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             addr_err,
    input logic [OFF_W-1:0] offset
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy, 1) && $past(busy, 2) && $past(busy, 3)));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (offset == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(offset) && $stable(addr_err)));

endmodule

bind chs_offset_unit chs_offset_chk #(.OFF_W(OFF_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .addr_err (addr_err),
    .offset   (offset)
);

// File: tb/chs_offset_unit_tb_top.sv
`timescale 1ns/1ps
module chs_offset_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        lba_mode = 1'b0;
    logic [7:0]  sec_num = '0;
    logic [7:0]  cyl_lo = '0;
    logic [7:0]  cyl_hi = '0;
    logic [7:0]  drv_head = '0;
    logic [4:0]  geo_heads = '0;
    logic [7:0]  geo_spt = '0;
    logic [15:0] sec_bytes = '0;
    logic        busy;
    logic        done;
    logic        addr_err;
    logic [47:0] offset;

    always #10 clk = ~clk;

    chs_offset_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lba_mode  (lba_mode),
        .sec_num   (sec_num),
        .cyl_lo    (cyl_lo),
        .cyl_hi    (cyl_hi),
        .drv_head  (drv_head),
        .geo_heads (geo_heads),
        .geo_spt   (geo_spt),
        .sec_bytes (sec_bytes),
        .busy      (busy),
        .done      (done),
        .addr_err  (addr_err),
        .offset    (offset)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string tag    = "R1";

    // behavioural reference
    int      m_phase = 0;
    bit      m_done  = 0;
    bit      m_err   = 0;
    longint  m_off   = 0;
    bit      p_err   = 0;
    longint  p_off   = 0;

    function automatic void predict(output bit e, output longint o);
        longint bytes, cyl, hd, idx;
        bytes = (sec_bytes == 0) ? 512 : longint'(sec_bytes);
        cyl   = longint'(cyl_hi) * 256 + longint'(cyl_lo);
        hd    = longint'(drv_head % 16);
        if (lba_mode) begin
            idx = cyl * 256 + longint'(sec_num);
            e = 0; o = idx * bytes;
        end else if (geo_heads == 0 || geo_spt == 0 || sec_num == 0) begin
            e = 1; o = 0;
        end else begin
            idx = (cyl * longint'(geo_heads) + hd) * longint'(geo_spt) + longint'(sec_num) - 1;
            e = 0; o = idx * bytes;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_done = 0; m_err = 0; m_off = 0;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (start) begin
                    predict(p_err, p_off);
                    m_phase = 1;
                end
            end else if (m_phase < 3) begin
                m_phase = m_phase + 1;
            end else begin
                m_phase = 0; m_done = 1; m_err = p_err; m_off = p_off;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog %s: actual=hung expected=finished", tag);
            summary();
        end
    end

    task automatic compare();
        n_vec++;
        if (busy !== (m_phase != 0)) begin
            n_fail++;
            $display("FAIL %s busy: actual=%0b expected=%0b", tag, busy, (m_phase != 0));
        end
        if (done !== m_done) begin
            n_fail++;
            $display("FAIL %s done: actual=%0b expected=%0b", tag, done, m_done);
        end
        if (addr_err !== m_err) begin
            n_fail++;
            $display("FAIL %s addr_err: actual=%0b expected=%0b", tag, addr_err, m_err);
        end
        if (offset !== 48'(m_off)) begin
            n_fail++;
            $display("FAIL %s offset: actual=%0h expected=%0h", tag, offset, 48'(m_off));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_in(input bit lba, input logic [7:0] s, input logic [7:0] cl,
                          input logic [7:0] ch, input logic [7:0] dh, input logic [4:0] h,
                          input logic [7:0] spt, input logic [15:0] b);
        lba_mode = lba; sec_num = s; cyl_lo = cl; cyl_hi = ch; drv_head = dh;
        geo_heads = h; geo_spt = spt; sec_bytes = b;
    endtask

    task automatic run_op(input string t, input bit lba, input logic [7:0] s,
                          input logic [7:0] cl, input logic [7:0] ch, input logic [7:0] dh,
                          input logic [4:0] h, input logic [7:0] spt, input logic [15:0] b);
        tag = t;
        set_in(lba, s, cl, ch, dh, h, spt, b);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 5; i++) tick();
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();

        // R4 / R9: basic translation and latency
        run_op("R4", 0, 8'd5, 8'd3, 8'd0, 8'h02, 5'd4, 8'd63, 16'd512);
        run_op("R9", 0, 8'd1, 8'd0, 8'd0, 8'h00, 5'd16, 8'd63, 16'd512);
        // R3: both cylinder halves
        run_op("R3", 0, 8'd9, 8'h34, 8'h12, 8'h01, 5'd15, 8'd17, 16'd512);
        run_op("R3", 0, 8'd9, 8'h00, 8'h01, 8'h01, 5'd15, 8'd17, 16'd512);
        // R2: upper drive/head bits ignored
        run_op("R2", 0, 8'd2, 8'd7, 8'd0, 8'hA7, 5'd8, 8'd32, 16'd512);
        run_op("R2", 0, 8'd2, 8'd7, 8'd0, 8'h07, 5'd8, 8'd32, 16'd512);
        // R5: zero geometry
        run_op("R5", 0, 8'd3, 8'd1, 8'd0, 8'h00, 5'd0, 8'd63, 16'd512);
        run_op("R5", 0, 8'd3, 8'd1, 8'd0, 8'h00, 5'd4, 8'd0, 16'd512);
        // R6: sector zero
        run_op("R6", 0, 8'd0, 8'd1, 8'd0, 8'h00, 5'd4, 8'd63, 16'd512);
        // R7: default and explicit sector size
        run_op("R7", 0, 8'd4, 8'd2, 8'd0, 8'h01, 5'd4, 8'd63, 16'd0);
        run_op("R7", 0, 8'd4, 8'd2, 8'd0, 8'h01, 5'd4, 8'd63, 16'd4096);
        // R8: linear mode ignores geometry
        run_op("R8", 1, 8'h56, 8'h34, 8'h12, 8'hFF, 5'd0, 8'd0, 16'd512);
        run_op("R8", 1, 8'hFF, 8'hFF, 8'hFF, 8'h00, 5'd3, 8'd9, 16'd0);
        // R4: largest geometry fits in 48 bits
        run_op("R4", 0, 8'd255, 8'hFF, 8'hFF, 8'h0F, 5'd16, 8'd255, 16'hFFFF);

        // R10: start while busy and input changes after acceptance
        tag = "R10";
        set_in(0, 8'd6, 8'd10, 8'd0, 8'h03, 5'd4, 8'd40, 16'd512);
        start = 1'b1;
        tick();
        set_in(1, 8'd99, 8'd77, 8'd5, 8'h0E, 5'd2, 8'd3, 16'd1024);
        tick();
        tick();
        start = 1'b0;
        for (int i = 0; i < 5; i++) tick();

        // R11: outputs hold while idle and inputs move
        tag = "R11";
        for (int i = 0; i < 6; i++) begin
            set_in(i[0], 8'(i * 7), 8'(i), 8'(i * 3), 8'(i), 5'(i), 8'(i), 16'(i * 100));
            tick();
        end

        // R9: back-to-back starts held high
        tag = "R9";
        set_in(0, 8'd12, 8'd4, 8'd0, 8'h05, 5'd6, 8'd20, 16'd256);
        start = 1'b1;
        for (int i = 0; i < 10; i++) tick();
        start = 1'b0;
        for (int i = 0; i < 5; i++) tick();

        // R1: reset in the middle of a conversion
        tag = "R1";
        start = 1'b1;
        tick();
        start = 1'b0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();

        summary();
    end

endmodule